// File: doc/BRIEF.md
# Page ECC Generator and Single-Bit Corrector

This block sits on the byte stream between a page buffer and a raw flash device. As page bytes flow past, it folds each byte into a 24-bit Hamming-style code for the current 512-byte chunk. When a chunk finishes, the code goes into one of four per-chunk result slots, and that slot is flagged as valid. A page holds one, two or four chunks, chosen by a page-size code. The final byte of a page can also be tagged, which closes the current chunk early. A busy output covers the whole page, up to the cycle in which the last code has been stored.

A separate correction path takes two codes. One is the code read back from the spare area, still bit-inverted as stored. The other is a freshly computed code. From these the path classifies the chunk and reports where a single flipped data bit lies. The block only reports the byte offset and bit offset: patching the data is left to the caller. Codes are kept inverted in flash, so an erased page (all ones in both data and spare) reads back as clean.

Top module: `page_ecc_engine`

## Requirements
- R1: Let p = {byte offset[8:0], bit index[2:0]} be the 12-bit position of a data bit inside its chunk. Code bit k (k in 0..11) is the XOR of every data bit whose p has bit k set. Code bit 12+k is the XOR of every data bit whose p has bit k clear. A chunk of all-ones bytes therefore codes to zero.
- R2: When a slot is valid, `rd_result` for the slot selected by `rd_sel` equals {8'h40, code[23:0]}: status bit 6 (bit 30 of the word) is the valid flag. When the slot is not valid, the whole word reads zero.
- R3: Page-size code 1 gives 1 chunk, code 2 gives 2 chunks and code 3 gives 4 chunks. Code 0 is treated as 1 chunk. The page closes by itself after that many full chunks.
- R4: A byte accepted with `in_last` high ends the page. The chunk in progress is closed with a code over only the bytes it received, and later slots stay invalid.
- R5: The first byte of a new page clears every valid flag. Slots that the new page does not reach read zero afterwards.
- R6: `busy` is high from the cycle after the first byte is accepted. It falls in the cycle after the edge that follows the final byte's acceptance. At that same edge the last code is stored.
- R7: `fix_stored` holds the three spare bytes as read ({byte2, byte1, byte0}). The corrector inverts them. The low half is {byte1[3:0], byte0} and the high half is {byte2, byte1[7:4]}. The odd syndrome is the XOR of the two low halves and the even syndrome is the XOR of the two high halves.
- R8: Both syndromes zero gives class 0 (clean). This includes stored 24'hFFFFFF against computed 24'h000000.
- R9: An odd syndrome equal to the 12-bit complement of the even syndrome gives class 1 (data corrected). In that case `fix_byte` = odd[11:3] and `fix_bit` = odd[2:0].
- R10: Exactly one set bit across both syndromes gives class 2 (error in the code only).
- R11: Every other syndrome pattern gives class 3 (uncorrectable).
- R12: Results appear one cycle after `fix_req`, with `fix_valid` high for that one cycle. `fix_byte` and `fix_bit` are zero unless the class is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_size | input | 2 | Chunks per page code, held stable during a page |
| in_valid | input | 1 | A page byte is presented this cycle |
| in_byte | input | 8 | Page data byte |
| in_last | input | 1 | This byte is the final one of the page |
| busy | output | 1 | Page code computation in progress |
| rd_sel | input | 2 | Result slot to read |
| rd_result | output | 32 | Selected slot: status byte and code |
| fix_req | input | 1 | Start a classification |
| fix_stored | input | 24 | Code read from the spare area, still inverted |
| fix_computed | input | 24 | Code computed over the data as read |
| fix_valid | output | 1 | Classification result strobe |
| fix_class | output | 2 | 0 clean, 1 corrected, 2 code-only, 3 uncorrectable |
| fix_byte | output | 9 | Byte offset of the bit to flip |
| fix_bit | output | 3 | Bit offset of the bit to flip |

## Verification
The hardest case to reach from the ports is a page that ends early, in the middle of a chunk. The partial chunk's code has to cover exactly the bytes received, and slots left over from an earlier full page have to read zero. The bench first fills all four slots with a full page, then streams a 700-byte page tagged as final, and checks the partial code against a bit-position model. The corrector is swept over all 4096 single-bit data positions, all 24 code-only flips and all 276 double-bit patterns.

// File: rtl/pecc_pkg.sv
// Shared types for the page ECC engine.
package pecc_pkg;
    typedef enum logic [1:0] {
        FIX_CLEAN = 2'd0,
        FIX_DATA  = 2'd1,
        FIX_CODE  = 2'd2,
        FIX_FAIL  = 2'd3
    } fix_class_e;

    localparam int STATUS_VALID_BIT = 6;
endpackage

// File: rtl/pecc_byte_parity.sv
// Per-byte code contribution.
// Produces the odd (set-bit) and even (clear-bit) parity terms one byte
// contributes at byte offset 'offset'. The low half uses bit-index terms in
// [2:0] and byte-offset terms above them; the high half mirrors it.
// Assumes byte-wide data.
module pecc_byte_parity #(
    parameter int BYTE_AW = 9,
    localparam int PW     = BYTE_AW + 3
) (
    input  logic [7:0]         data,
    input  logic [BYTE_AW-1:0] offset,
    output logic [2*PW-1:0]    contrib
);
    logic          total;
    logic [PW-1:0] lo;
    logic [PW-1:0] hi;

    // Overall parity of the byte feeds every byte-offset term.
    assign total = ^data;

    genvar gc;
    for (gc = 0; gc < 3; gc++) begin : g_col
        localparam logic [7:0] SEL = (gc == 0) ? 8'hAA : ((gc == 1) ? 8'hCC : 8'hF0);
        // Column terms: bits whose index has bit gc set / clear.
        assign lo[gc] = ^(data & SEL);
        assign hi[gc] = ^(data & ~SEL);
    end

    genvar gl;
    for (gl = 0; gl < BYTE_AW; gl++) begin : g_line
        // Line terms: the whole byte lands on the odd or the even side.
        assign lo[gl+3] = offset[gl] & total;
        assign hi[gl+3] = ~offset[gl] & total;
    end

    assign contrib = {hi, lo};
endmodule

// File: rtl/pecc_chunk_gen.sv
// Streaming code generator.
// Stage 0 counts bytes and chunks and decides chunk/page boundaries.
// Stage 1 folds the registered byte into the running code and emits a commit
// when a chunk closes. Assumes page_size is stable while a page is open.
module pecc_chunk_gen #(
    parameter int CHUNK_BYTES = 512,
    parameter int MAX_CHUNKS  = 4,
    localparam int BYTE_AW    = $clog2(CHUNK_BYTES),
    localparam int CW         = $clog2(MAX_CHUNKS),
    localparam int CODE_W     = 2 * (BYTE_AW + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        page_size,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    output logic              commit_valid,
    output logic [CW-1:0]     commit_idx,
    output logic [CODE_W-1:0] commit_code,
    output logic              clear_all,
    output logic              busy
);
    logic [BYTE_AW-1:0] byte_cnt;
    logic [CW-1:0]      chunk_cnt;
    logic               page_open;
    logic [CW-1:0]      last_idx;
    logic               chunk_end0;
    logic               page_end0;

    logic               s1_valid;
    logic [7:0]         s1_byte;
    logic [BYTE_AW-1:0] s1_off;
    logic               s1_end;
    logic               s1_start;
    logic [CW-1:0]      s1_idx;

    logic [CODE_W-1:0]  acc;
    logic [CODE_W-1:0]  contrib;
    logic [CODE_W-1:0]  acc_n;

    // Index of the final chunk for the configured page size.
    always_comb begin
        int raw;
        case (page_size)
            2'd2:    raw = 1;
            2'd3:    raw = 3;
            default: raw = 0;
        endcase
        if (raw > MAX_CHUNKS - 1) raw = MAX_CHUNKS - 1;
        last_idx = CW'(raw);
    end

    // Boundary decisions for the byte presented now.
    assign chunk_end0 = in_last | (byte_cnt == BYTE_AW'(CHUNK_BYTES - 1));
    assign page_end0  = in_last | ((byte_cnt == BYTE_AW'(CHUNK_BYTES - 1)) && (chunk_cnt == last_idx));

    // Stage 0 position counters and page-open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt  <= '0;
            chunk_cnt <= '0;
            page_open <= 1'b0;
        end else if (in_valid) begin
            page_open <= !page_end0;
            if (page_end0) begin
                byte_cnt  <= '0;
                chunk_cnt <= '0;
            end else if (chunk_end0) begin
                byte_cnt  <= '0;
                chunk_cnt <= chunk_cnt + 1'b1;
            end else begin
                byte_cnt <= byte_cnt + 1'b1;
            end
        end
    end

    // Stage 1 register: byte plus its position and boundary tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_byte  <= '0;
            s1_off   <= '0;
            s1_end   <= 1'b0;
            s1_start <= 1'b0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_byte  <= in_byte;
            s1_off   <= byte_cnt;
            s1_end   <= chunk_end0;
            s1_start <= !page_open;
            s1_idx   <= chunk_cnt;
        end
    end

    pecc_byte_parity #(.BYTE_AW(BYTE_AW)) u_parity (
        .data    (s1_byte),
        .offset  (s1_off),
        .contrib (contrib)
    );

    assign acc_n = acc ^ contrib;

    // Running code: folds each byte and restarts after a chunk closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (s1_valid) begin
            acc <= s1_end ? '0 : acc_n;
        end
    end

    assign commit_valid = s1_valid & s1_end;
    assign commit_idx   = s1_idx;
    assign commit_code  = acc_n;
    assign clear_all    = s1_valid & s1_start;
    assign busy         = page_open | s1_valid;

    p_acc_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_end) |=> (acc == '0));

    p_chunk_in_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        page_open |-> (chunk_cnt <= last_idx));

    p_last_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (!page_open && s1_end));
endmodule

// File: rtl/pecc_result_bank.sv
// Per-chunk result slots.
// Each slot holds a code and a valid flag. A commit writes one slot and sets
// its flag; a page-start clear drops every other flag in the same cycle.
// Reads are combinational.
module pecc_result_bank #(
    parameter int MAX_CHUNKS = 4,
    parameter int CODE_W     = 24,
    localparam int CW        = $clog2(MAX_CHUNKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_idx,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              clear_all,
    input  logic [CW-1:0]     rd_sel,
    output logic              rd_valid,
    output logic [CODE_W-1:0] rd_code
);
    logic [MAX_CHUNKS-1:0] flags;
    logic [CODE_W-1:0]     codes [MAX_CHUNKS];

    genvar gi;
    for (gi = 0; gi < MAX_CHUNKS; gi++) begin : g_slot
        logic              flag_q;
        logic [CODE_W-1:0] code_q;

        // Slot write takes priority over the page-start clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                code_q <= '0;
            end else if (wr_en && (wr_idx == CW'(gi))) begin
                flag_q <= 1'b1;
                code_q <= wr_code;
            end else if (clear_all) begin
                flag_q <= 1'b0;
            end
        end

        assign flags[gi] = flag_q;
        assign codes[gi] = code_q;
    end

    assign rd_valid = flags[rd_sel];
    assign rd_code  = codes[rd_sel];

    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && !wr_en) |=> (flags == '0));

    p_write_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags[$past(wr_idx)]);
endmodule

// File: rtl/pecc_syndrome_decoder.sv
// Correction classifier.
// Inverts the stored code, forms the odd/even syndromes and registers a class
// and flip position one cycle after a request. Position is zero unless the
// class is a data correction.
module pecc_syndrome_decoder
    import pecc_pkg::*;
#(
    parameter int BYTE_AW = 9,
    localparam int PW     = BYTE_AW + 3,
    localparam int CODE_W = 2 * PW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [CODE_W-1:0]  stored,
    input  logic [CODE_W-1:0]  computed,
    output logic               res_valid,
    output fix_class_e         res_class,
    output logic [BYTE_AW-1:0] res_byte,
    output logic [2:0]         res_bit
);
    logic [CODE_W-1:0] syn;
    logic [PW-1:0]     syn_odd;
    logic [PW-1:0]     syn_even;
    fix_class_e        cls;

    // Syndrome of the re-inverted stored code against the computed one.
    assign syn      = (~stored) ^ computed;
    assign syn_odd  = syn[PW-1:0];
    assign syn_even = syn[CODE_W-1:PW];

    // Classification in priority order.
    always_comb begin
        if (syn == '0)
            cls = FIX_CLEAN;
        else if (syn_odd == ~syn_even)
            cls = FIX_DATA;
        else if ($countones(syn) == 1)
            cls = FIX_CODE;
        else
            cls = FIX_FAIL;
    end

    // Result register with one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_class <= FIX_CLEAN;
            res_byte  <= '0;
            res_bit   <= '0;
        end else begin
            res_valid <= req;
            if (req) begin
                res_class <= cls;
                res_byte  <= (cls == FIX_DATA) ? syn_odd[PW-1:3] : '0;
                res_bit   <= (cls == FIX_DATA) ? syn_odd[2:0]    : '0;
            end
        end
    end

    p_strobe_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(req));

    p_pos_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class != FIX_DATA) |-> (res_byte == '0 && res_bit == '0));

    p_clean_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == FIX_CLEAN) |-> $past((~stored) == computed));
endmodule

// File: rtl/page_ecc_engine.sv
// Page ECC engine top.
// Streams page bytes through the chunk generator into the result bank and
// exposes the independent syndrome decoder. Assumes CHUNK_BYTES <= 512 so the
// code fits the 24-bit field of the result word.
module page_ecc_engine
    import pecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 512,
    parameter int MAX_CHUNKS  = 4,
    localparam int BYTE_AW    = $clog2(CHUNK_BYTES),
    localparam int CW         = $clog2(MAX_CHUNKS),
    localparam int CODE_W     = 2 * (BYTE_AW + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         page_size,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    input  logic               in_last,
    output logic               busy,
    input  logic [CW-1:0]      rd_sel,
    output logic [31:0]        rd_result,
    input  logic               fix_req,
    input  logic [CODE_W-1:0]  fix_stored,
    input  logic [CODE_W-1:0]  fix_computed,
    output logic               fix_valid,
    output logic [1:0]         fix_class,
    output logic [BYTE_AW-1:0] fix_byte,
    output logic [2:0]         fix_bit
);
    logic              commit_valid;
    logic [CW-1:0]     commit_idx;
    logic [CODE_W-1:0] commit_code;
    logic              clear_all;
    logic              rd_valid;
    logic [CODE_W-1:0] rd_code;
    fix_class_e        cls;

    pecc_chunk_gen #(.CHUNK_BYTES(CHUNK_BYTES), .MAX_CHUNKS(MAX_CHUNKS)) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_size    (page_size),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_last      (in_last),
        .commit_valid (commit_valid),
        .commit_idx   (commit_idx),
        .commit_code  (commit_code),
        .clear_all    (clear_all),
        .busy         (busy)
    );

    pecc_result_bank #(.MAX_CHUNKS(MAX_CHUNKS), .CODE_W(CODE_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit_valid),
        .wr_idx    (commit_idx),
        .wr_code   (commit_code),
        .clear_all (clear_all),
        .rd_sel    (rd_sel),
        .rd_valid  (rd_valid),
        .rd_code   (rd_code)
    );

    pecc_syndrome_decoder #(.BYTE_AW(BYTE_AW)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (fix_req),
        .stored    (fix_stored),
        .computed  (fix_computed),
        .res_valid (fix_valid),
        .res_class (cls),
        .res_byte  (fix_byte),
        .res_bit   (fix_bit)
    );

    assign fix_class = cls;

    // Result word: status byte with valid flag, code zero-extended to 24 bits.
    assign rd_result = rd_valid ? {8'(1 << STATUS_VALID_BIT), 24'(rd_code)} : 32'h0;

    p_busy_falls_on_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit_valid));
endmodule

// File: tb/page_ecc_engine_bench.sv
module page_ecc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  page_size = 2'd0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h0;
    logic        in_last = 1'b0;
    logic        busy;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_result;
    logic        fix_req = 1'b0;
    logic [23:0] fix_stored = 24'h0;
    logic [23:0] fix_computed = 24'h0;
    logic        fix_valid;
    logic [1:0]  fix_class;
    logic [8:0]  fix_byte;
    logic [2:0]  fix_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    page_ecc_engine u_page_ecc_engine (
        .clk(clk), .rst_n(rst_n), .page_size(page_size),
        .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
        .busy(busy), .rd_sel(rd_sel), .rd_result(rd_result),
        .fix_req(fix_req), .fix_stored(fix_stored), .fix_computed(fix_computed),
        .fix_valid(fix_valid), .fix_class(fix_class),
        .fix_byte(fix_byte), .fix_bit(fix_bit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        if (seed == 999) return 8'hFF;
        return 8'((i * (2 * seed + 1)) ^ (seed * 37) ^ (i >> 4));
    endfunction

    // Bit-position model: each set bit XORs its position into the low half
    // and the complement of its position into the high half.
    function automatic logic [23:0] model_code(input int seed, input int first, input int count);
        logic [11:0] lo = 12'h0;
        logic [11:0] hi = 12'h0;
        for (int a = 0; a < count; a++) begin
            logic [7:0] d = pat(seed, first + a);
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    logic [11:0] p = 12'((a << 3) | b);
                    lo ^= p;
                    hi ^= ~p;
                end
            end
        end
        return {hi, lo};
    endfunction

    task automatic send_page(input logic [1:0] sz, input int nbytes, input int seed, input bit use_last);
        page_size = sz;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = pat(seed, i);
            in_last  = use_last && (i == nbytes - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(busy == 1'b1, "R6", "busy held after final byte", 32'(busy), 32'h1);
        @(negedge clk);
        chk(busy == 1'b0, "R6", "busy dropped once stored", 32'(busy), 32'h0);
    endtask

    task automatic expect_slot(input int slot, input bit valid, input logic [23:0] code, input string req);
        logic [31:0] exp = valid ? {8'h40, code} : 32'h0;
        rd_sel = 2'(slot);
        #1;
        chk(rd_result == exp, req, $sformatf("slot %0d word", slot), rd_result, exp);
    endtask

    task automatic fix_check(input logic [23:0] st, input logic [23:0] cp, input logic [1:0] ecls,
                             input logic [8:0] eb, input logic [2:0] ebit, input string req);
        @(negedge clk);
        fix_req = 1'b1;
        fix_stored = st;
        fix_computed = cp;
        @(negedge clk);
        fix_req = 1'b0;
        chk(fix_valid && fix_class == ecls && fix_byte == eb && fix_bit == ebit, req,
            "class/byte/bit",
            {fix_valid, 16'h0, fix_class, fix_byte, fix_bit},
            {1'b1, 16'h0, ecls, eb, ebit});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(busy == 1'b0, "R6", "busy after reset", 32'(busy), 32'h0);
        chk(fix_valid == 1'b0, "R12", "no strobe after reset", 32'(fix_valid), 32'h0);
        for (int s = 0; s < 4; s++) expect_slot(s, 1'b0, 24'h0, "R2");

        // Full four-chunk page (R3, R1, R2)
        send_page(2'd3, 2048, 3, 1'b0);
        for (int s = 0; s < 4; s++) expect_slot(s, 1'b1, model_code(3, 512 * s, 512), "R1");

        // One-chunk page clears older slots (R5, R3)
        send_page(2'd1, 512, 5, 1'b0);
        expect_slot(0, 1'b1, model_code(5, 0, 512), "R3");
        for (int s = 1; s < 4; s++) expect_slot(s, 1'b0, 24'h0, "R5");

        // Two-chunk page
        send_page(2'd2, 1024, 7, 1'b0);
        expect_slot(0, 1'b1, model_code(7, 0, 512), "R3");
        expect_slot(1, 1'b1, model_code(7, 512, 512), "R3");
        expect_slot(2, 1'b0, 24'h0, "R3");

        // Code 0 behaves as one chunk
        send_page(2'd0, 512, 11, 1'b0);
        expect_slot(0, 1'b1, model_code(11, 0, 512), "R3");
        expect_slot(1, 1'b0, 24'h0, "R3");

        // Refill, then an early-ending page (R4)
        send_page(2'd3, 2048, 4, 1'b0);
        send_page(2'd3, 700, 13, 1'b1);
        expect_slot(0, 1'b1, model_code(13, 0, 512), "R4");
        expect_slot(1, 1'b1, model_code(13, 512, 188), "R4");
        expect_slot(2, 1'b0, 24'h0, "R4");
        expect_slot(3, 1'b0, 24'h0, "R4");

        // Erased chunk codes to zero
        send_page(2'd1, 512, 999, 1'b0);
        expect_slot(0, 1'b1, 24'h0, "R1");

        // Single-byte page holding one set bit at position 0: low 0, high all ones
        page_size = 2'd3;
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h01; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        expect_slot(0, 1'b1, 24'hFFF000, "R4");
        expect_slot(1, 1'b0, 24'h0, "R5");

        // Corrector: clean and erased (R7, R8)
        fix_check(~24'h5A3C96, 24'h5A3C96, 2'd0, 9'h0, 3'h0, "R8");
        fix_check(24'hFFFFFF, 24'h000000, 2'd0, 9'h0, 3'h0, "R8");
        // Byte order: flip in stored byte1 upper nibble is a high-half bit
        fix_check(~(24'h123456 ^ 24'h001000), 24'h123456, 2'd2, 9'h0, 3'h0, "R7");

        // Every single-bit data position (R9)
        for (int p = 0; p < 4096; p++) begin
            logic [11:0] pp = 12'(p);
            logic [23:0] cp = 24'(p * 40503 + 17);
            fix_check(~(cp ^ {~pp, pp}), cp, 2'd1, pp[11:3], pp[2:0], "R9");
        end

        // Every single code-bit flip (R10)
        for (int k = 0; k < 24; k++) begin
            logic [23:0] cp = 24'(k * 9973 + 5);
            fix_check(~(cp ^ (24'h1 << k)), cp, 2'd2, 9'h0, 3'h0, "R10");
        end

        // Every double-bit pattern (R11)
        for (int i = 0; i < 24; i++) begin
            for (int j = i + 1; j < 24; j++) begin
                logic [23:0] cp = 24'(i * 311 + j * 7919);
                fix_check(~(cp ^ (24'h1 << i) ^ (24'h1 << j)), cp, 2'd3, 9'h0, 3'h0, "R11");
            end
        end

        // Strobe lasts one cycle (R12)
        @(negedge clk);
        chk(fix_valid == 1'b0, "R12", "strobe single cycle", 32'(fix_valid), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule